// File: doc/BRIEF.md
# Watchdog Timer with Timed Reconfiguration Lock

This block is a watchdog timer for a small microcontroller. A free-running counter advances on a slow tick input and is cleared by a restart strobe (a kick) from firmware. If kicks stop arriving, for example because the firmware is stuck in an endless loop, the counter reaches the timeout chosen by a 3-bit timeout code. The block then raises a one-cycle system reset request and sets a sticky watchdog-reset flag.

The timeout code and the enable bit are guarded against stray writes. Firmware first writes the control register with both the change-enable bit and the enable bit set. This opens a four-clock window. A second control write with change-enable cleared, made inside that window, loads the new enable and timeout code. Control writes made outside the window cannot change the timeout code and cannot clear the enable bit. They can only turn the watchdog on.

Top module: `wdt_top`

## Requirements
- R1: After reset, the control readback is 0 (enable off, window closed, timeout code 0), the status flag is 0 and no reset request is raised.
- R2: A control write (regSel=0) with bit 1 (change-enable) and bit 0 (enable) both set sets the enable bit and opens the window. Readback bit 1 is 1 in the four cycles after that write and clears by itself on the fifth.
- R3: A control write with bit 1 clear, made 1 to 4 clock cycles after the unlock write, loads bit 0 into enable and bits 4:2 into the timeout code, and closes the window. The same write made 5 or more cycles after the unlock write changes neither field.
- R4: A control write with bit 1 clear, made while the window is closed, leaves the timeout code unchanged and never clears enable. It sets enable when bit 0 is 1 and enable was 0.
- R5: A control write with bit 1 set and bit 0 clear changes neither enable nor the timeout code and does not open the window.
- R6: While enabled, with timeout code c, the reset request goes high in the cycle after the 2^(BASE_EXP+c)-th counted tick edge since the counter was last cleared. It stays high for exactly one cycle and the count restarts from zero. No request is raised while disabled.
- R7: The counter advances only on clock edges where tick is 1 and the watchdog is enabled. A kick clears the counter and takes priority over a tick on the same edge.
- R8: Each expiry sets the status flag (statusRd). A status write (regSel=1) with bit 0 = 0 clears it, a status write with bit 0 = 1 leaves it alone, and an expiry on the same edge as a clearing write leaves the flag set.
- R9: An accepted configuration write, or a write that turns enable on, clears the counter, so the next timeout is a full period from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow time-base enable; one count per clock with tick high |
| kick | input | 1 | Restart strobe, clears the counter |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects control, 1 selects status |
| regWrData | input | 5 | Write data: bit 0 enable, bit 1 change-enable, bits 4:2 timeout code |
| ctrlRd | output | 5 | Control readback in the same layout as regWrData |
| statusRd | output | 1 | Sticky watchdog-reset flag |
| wdtRstReq | output | 1 | One-cycle system reset request on expiry |

## Verification
The assertions take for granted that a new unlock write is not made while the window from an earlier one is still open, since the window-length check counts from the most recent unlock. The stimulus keeps to this by always letting a window close, or closing it with a completing write, before it unlocks again. The assertions also take for granted that kick and tick are single-cycle-sampled levels with no relation to the register writes. The random phase draws these levels freely, except in the directed timing cases, which hold tick steady so that each expiry can be timed exactly.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // width of the timeout code field
  localparam int PRE_W = 3;
  // control field positions
  localparam int EN_BIT = 0;
  localparam int CHG_BIT = 1;
  localparam int PRE_LSB = 2;
  localparam int CTRL_W = PRE_LSB + PRE_W;

  // strobes from the register control to the datapath
  typedef struct packed {
    logic             cfgLoad;  // load enable and code together
    logic             enForce;  // turn enable on
    logic             cntClr;   // restart the count
    logic             flagClr;  // clear sticky flag
    logic             newEn;
    logic [PRE_W-1:0] newPre;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              curEn,
  output wdtStrobe_t        strobe,
  output logic              chgEn
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] winCnt;
  logic wrCtrl, wrStat, isUnlock, isCommit, winOpen;

  assign wrCtrl   = regWrEn & ~regSel;
  assign wrStat   = regWrEn & regSel;
  assign isUnlock = wrCtrl & regWrData[CHG_BIT] & regWrData[EN_BIT];
  assign isCommit = wrCtrl & ~regWrData[CHG_BIT];
  assign winOpen  = (winCnt != '0);
  assign chgEn    = winOpen;

  always_comb begin
    strobe = '0;
    strobe.newEn  = regWrData[EN_BIT];
    strobe.newPre = regWrData[PRE_LSB +: PRE_W];
    if (isCommit) begin
      if (winOpen) begin
        strobe.cfgLoad = 1'b1;
        strobe.cntClr  = 1'b1;
      end else if (regWrData[EN_BIT] && !curEn) begin
        strobe.enForce = 1'b1;
        strobe.cntClr  = 1'b1;
      end
    end
    if (isUnlock && !curEn) begin
      strobe.enForce = 1'b1;
      strobe.cntClr  = 1'b1;
    end
    strobe.flagClr = wrStat & ~regWrData[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (isUnlock) begin
      winCnt <= WIN_W'(WINDOW);
    end else if (isCommit && winOpen) begin
      winCnt <= '0;
    end else if (winOpen) begin
      winCnt <= winCnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_datapath.sv
`timescale 1ns/1ps
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kick,
  input  wdtStrobe_t       strobe,
  output logic             en,
  output logic [PRE_W-1:0] pre,
  output logic             flag,
  output logic             rstReq
);
  localparam int CNT_W = BASE_EXP + (1 << PRE_W);
  localparam int TAP_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt, nextCnt;
  logic [TAP_W-1:0] tapIdx;
  logic expire;

  assign nextCnt = cnt + 1'b1;
  assign tapIdx  = TAP_W'(BASE_EXP) + TAP_W'(pre);
  assign expire  = en & tick & ~kick & nextCnt[tapIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en     <= 1'b0;
      pre    <= '0;
      cnt    <= '0;
      flag   <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= expire;
      if (strobe.cfgLoad) begin
        en  <= strobe.newEn;
        pre <= strobe.newPre;
      end else if (strobe.enForce) begin
        en <= 1'b1;
      end
      if (kick || strobe.cntClr || expire || !en) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= nextCnt;
      end
      if (expire) begin
        flag <= 1'b1;
      end else if (strobe.flagClr) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int WINDOW   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              kick,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] ctrlRd,
  output logic              statusRd,
  output logic              wdtRstReq
);
  wdtStrobe_t       strobe;
  logic             en, chgEn, flag;
  logic [PRE_W-1:0] pre;

  wdt_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .curEn(en), .strobe(strobe), .chgEn(chgEn)
  );

  wdt_datapath #(.BASE_EXP(BASE_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .strobe(strobe),
    .en(en), .pre(pre), .flag(flag), .rstReq(wdtRstReq)
  );

  assign ctrlRd   = {pre, chgEn, en};
  assign statusRd = flag;
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              kick,
  input logic              regWrEn,
  input logic              regSel,
  input logic [CTRL_W-1:0] regWrData,
  input logic [CTRL_W-1:0] ctrlRd,
  input logic              statusRd,
  input logic              wdtRstReq
);
  logic en, chg, unlockWr;
  logic [PRE_W-1:0] pre;
  int unsigned openRun;

  assign en  = ctrlRd[EN_BIT];
  assign chg = ctrlRd[CHG_BIT];
  assign pre = ctrlRd[PRE_LSB +: PRE_W];
  assign unlockWr = regWrEn & ~regSel & regWrData[CHG_BIT] & regWrData[EN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN || unlockWr) openRun <= 0;
    else if (chg) openRun <= openRun + 1;
  end

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
    chg |-> (openRun < WINDOW)); // R2
  AST_PRE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pre) |-> $past(chg)); // R4
  AST_EN_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(en) |-> $past(chg)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstReq |=> !wdtRstReq); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !wdtRstReq); // R6
  AST_KICK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !wdtRstReq); // R7
  AST_FLAG_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstReq |-> statusRd); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusRd) |-> $past(regWrEn && regSel && !regWrData[0])); // R8
endmodule

bind wdt_top wdt_checker #(.WINDOW(WINDOW)) u_wdt_checker (
  .clk(clk), .rstN(rstN), .kick(kick), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .ctrlRd(ctrlRd), .statusRd(statusRd),
  .wdtRstReq(wdtRstReq)
);

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;
  localparam int BASE = 4;
  localparam int WIN  = 4;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, kick = 1'b0;
  logic regWrEn = 1'b0, regSel = 1'b0;
  logic [4:0] regWrData = '0;
  logic [4:0] ctrlRd;
  logic statusRd, wdtRstReq;

  int nChecks = 0, nErrors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  wdt_top #(.BASE_EXP(BASE), .WINDOW(WIN)) i_wdt_top (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .ctrlRd(ctrlRd),
    .statusRd(statusRd), .wdtRstReq(wdtRstReq)
  );

  function automatic logic [4:0] expCtrl(logic en, logic chg, logic [2:0] pre);
    return {pre, chg, en};
  endfunction
  function automatic int expTicks(int code);
    return 1 << (BASE + code);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: act=%0d cycles exp=done", cycles);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write takes place on the following posedge
  task automatic wrReg(logic sel, logic [4:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic configure(logic en, logic [2:0] pre);
    wrReg(1'b0, 5'b000_11);
    wrReg(1'b0, {pre, 1'b0, en});
  endtask

  // counts tick edges until the request is seen, tick held high
  task automatic countToReq(output int n);
    n = 0;
    tick = 1'b1;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (wdtRstReq) break;
    end
  endtask

  logic mEn;
  logic [2:0] mPre;

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 ctrl", 32'(ctrlRd), 0);
    check("R1 status", 32'(statusRd), 0);
    check("R1 req", 32'(wdtRstReq), 0);

    // R5 change-enable without enable does nothing
    wrReg(1'b0, {3'd3, 1'b1, 1'b0});
    check("R5 ctrl", 32'(ctrlRd), 32'(expCtrl(0, 0, 0)));
    @(negedge clk);
    check("R5 no window", 32'(ctrlRd), 32'(expCtrl(0, 0, 0)));

    // R4 locked write may set enable but not the code
    wrReg(1'b0, {3'd5, 1'b0, 1'b1});
    check("R4 en set", 32'(ctrlRd), 32'(expCtrl(1, 0, 0)));
    wrReg(1'b0, {3'd6, 1'b0, 1'b0});
    check("R4 no clear", 32'(ctrlRd), 32'(expCtrl(1, 0, 0)));

    // R2 window length
    wrReg(1'b0, 5'b000_11);
    check("R2 open c1", 32'(ctrlRd[1]), 1);
    repeat (3) @(negedge clk);
    check("R2 open c4", 32'(ctrlRd[1]), 1);
    @(negedge clk);
    check("R2 closed c5", 32'(ctrlRd[1]), 0);

    // R3 directed: cycle 4 accepted, cycle 5 rejected
    wrReg(1'b0, 5'b000_11);
    repeat (3) @(negedge clk);
    wrReg(1'b0, {3'd2, 1'b0, 1'b1});
    check("R3 cycle4 accepted", 32'(ctrlRd), 32'(expCtrl(1, 0, 2)));
    wrReg(1'b0, 5'b000_11);
    repeat (4) @(negedge clk);
    wrReg(1'b0, {3'd7, 1'b0, 1'b1});
    check("R3 cycle5 rejected", 32'(ctrlRd), 32'(expCtrl(1, 0, 2)));

    // R3/R4 random mix against a model
    mEn = 1'b1; mPre = 3'd2;
    for (int i = 0; i < 40; i++) begin
      int d;
      logic [2:0] np;
      logic ne;
      d  = $urandom_range(1, 7);
      np = 3'($urandom_range(0, 7));
      ne = 1'($urandom_range(0, 1));
      kick = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) begin
        wrReg(1'b0, {np, 1'b0, ne});
        mEn = mEn | ne;
        check("R4 random locked", 32'(ctrlRd), 32'(expCtrl(mEn, 0, mPre)));
      end else begin
        wrReg(1'b0, 5'b000_11);
        mEn = 1'b1;
        repeat (d - 1) @(negedge clk);
        wrReg(1'b0, {np, 1'b0, ne});
        if (d <= WIN) begin mEn = ne; mPre = np; end
        else mEn = mEn | ne;
        check("R3 random window", 32'(ctrlRd), 32'(expCtrl(mEn, 0, mPre)));
      end
    end
    kick = 1'b0;

    // R6 expiry time per code, R8 flag behaviour
    for (int c = 0; c < 8; c++) begin
      tick = 1'b0;
      configure(1'b1, 3'(c));
      countToReq(n);
      check($sformatf("R6 ticks code %0d", c), 32'(n), 32'(expTicks(c)));
      check("R8 flag set", 32'(statusRd), 1);
      @(negedge clk);
      check("R6 single pulse", 32'(wdtRstReq), 0);
      tick = 1'b0;
      wrReg(1'b1, 5'b00001);
      check("R8 write one keeps", 32'(statusRd), 1);
      wrReg(1'b1, 5'b00000);
      check("R8 write zero clears", 32'(statusRd), 0);
    end

    // R6 count restarts after expiry
    configure(1'b1, 3'd0);
    countToReq(n);
    countToReq(n);
    check("R6 restart period", 32'(n), 32'(expTicks(0)));
    tick = 1'b0;

    // R7 tick low does not count, kick clears
    configure(1'b1, 3'd0);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    repeat (30) @(negedge clk);
    check("R7 idle tick no req", 32'(wdtRstReq), 0);
    tick = 1'b1; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check("R7 kick no req", 32'(wdtRstReq), 0);
    countToReq(n);
    check("R7 full period after kick", 32'(n), 32'(expTicks(0)));
    tick = 1'b0;

    // R9 reconfig clears accumulated count
    configure(1'b1, 3'd1);
    tick = 1'b1;
    repeat (20) @(negedge clk);
    tick = 1'b0;
    configure(1'b1, 3'd1);
    countToReq(n);
    check("R9 full period after reconfig", 32'(n), 32'(expTicks(1)));
    tick = 1'b0;
    wrReg(1'b1, 5'b00000);

    // R8 expiry wins over a clearing write on the same edge
    configure(1'b1, 3'd0);
    tick = 1'b1;
    repeat (expTicks(0) - 1) @(negedge clk);
    wrReg(1'b1, 5'b00000);
    check("R8 same-edge req", 32'(wdtRstReq), 1);
    check("R8 set wins", 32'(statusRd), 1);
    tick = 1'b0;

    // R6 disabled watchdog never requests
    configure(1'b0, 3'd0);
    check("R6 disabled ctrl", 32'(ctrlRd), 32'(expCtrl(0, 0, 0)));
    tick = 1'b1;
    repeat (100) @(negedge clk);
    check("R6 disabled no req", 32'(wdtRstReq), 0);
    tick = 1'b0;

    summary();
  end
endmodule